// File: doc/BRIEF.md
# Battery presence detection sequencer

This block decides whether a cell is attached to the charger output. It does not read a voltage. It probes the node and watches two comparator flags. The first probe turns on a small discharge sink, which pulls the node down. The second probe turns on a weak wake charge, which pushes the node up. Each probe has its own timeout window, counted in millisecond ticks. The result depends on which thing happens first: a comparator flag crossing its threshold, or the window running out.

- If the sink window expires before the node sags, a battery is present.
- If the wake window expires before the node rises, a battery is present.
- If the node rises quickly during the wake probe, there is no battery. The sequencer reports absent, waits out a short gap with both sources off, and starts probing again.
- After a present result, the sequencer waits in a monitoring state. If the recharge comparator falls there, it runs the probe again.

A level start request from the charge controller enables the sequencer. Dropping that request returns the sequencer to idle at once.

Top module: `bdet_seq`

## Requirements
- R1: While `rst_ni` is low, all four outputs are 0.
- R2: In idle, with `start_i` high, `sink_en_o` is 1 in the next cycle.
- R3: During the sink probe, `low_v_i` high turns both sources off in the next cycle. The gap then lasts GAP_TICKS ticks, after which `wake_en_o` turns on. If `low_v_i` and the final window tick arrive in the same cycle, `low_v_i` wins.
- R4: During the sink probe, the SINK_TICKS-th tick since entry, with `low_v_i` still low, turns the sink off and raises `present_o`.
- R5: During the wake probe, `rech_hi_i` high sets `absent_o` and turns both sources off in the next cycle. After a gap of GAP_TICKS ticks, the sink probe starts again.
- R6: During the wake probe, the WAKE_TICKS-th tick since entry, with `rech_hi_i` still low, turns the wake source off and raises `present_o`.
- R7: `present_o` is high for exactly one cycle. `absent_o` stays high, also through idle, until the next present result clears it or a reset clears it.
- R8: `sink_en_o` and `wake_en_o` are never high together. Each one rises only after a cycle in which the other was low.
- R9: `start_i` low takes the sequencer to idle in the next cycle, with both sources off. The value of `absent_o` is kept.
- R10: After a present result, with `start_i` still high, a 1-to-0 step of `rech_hi_i` restarts the sink probe in the next cycle. A rising `rech_hi_i` has no effect in this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Level request that enables detection |
| tick_i | input | 1 | One-cycle millisecond tick |
| low_v_i | input | 1 | Node is below the low-voltage threshold |
| rech_hi_i | input | 1 | Node is above the recharge threshold |
| sink_en_o | output | 1 | Discharge sink enable |
| wake_en_o | output | 1 | Wake charge current enable |
| present_o | output | 1 | One-cycle pulse: battery found |
| absent_o | output | 1 | Level: latest result was no battery |

## Verification
A corrupted phase state shows up at the two source enables, or at the outcome flags, within one cycle of the next comparator event. An off-by-one tick counter shows up in a different way. A present pulse arrives one tick early or late against the window length, or the wake source comes on before or after the gap has run out. The bench therefore samples the enables just before and just after each window's final tick. It also checks the cycle right after every comparator change, so that each fault appears within a tick of its cause.

// File: rtl/bdet_pkg.sv
package bdet_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SINK,
    ST_GAP_W,
    ST_WAKE,
    ST_GAP_S,
    ST_MON
  } bdet_state_e;

  typedef enum logic [1:0] {
    WIN_NONE,
    WIN_SINK,
    WIN_GAP,
    WIN_WAKE
  } bdet_win_e;

endpackage

// File: rtl/bdet_win_timer.sv
module bdet_win_timer
  import bdet_pkg::*;
#(
  parameter int SINK_TICKS = 1000,
  parameter int WAKE_TICKS = 500,
  parameter int GAP_TICKS  = 1,
  parameter int CW         = 10
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      tick_i,
  input  bdet_win_e win_i,
  output logic      expire_o
);

  localparam logic [CW-1:0] SINK_LAST = CW'(SINK_TICKS - 1);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_TICKS - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  always_comb begin
    case (win_i)
      WIN_SINK: last = SINK_LAST;
      WIN_WAKE: last = WAKE_LAST;
      WIN_GAP:  last = GAP_LAST;
      default:  last = '0;
    endcase
  end

  // The tick that completes the window fires expire; the count then restarts on phase change.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (tick_i && win_i != WIN_NONE) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = tick_i && (win_i != WIN_NONE) && (cnt_q == last);

endmodule

// File: rtl/bdet_fall_det.sv
module bdet_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);

  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign fall_o = lvl_q && !lvl_i;

endmodule

// File: rtl/bdet_fsm.sv
module bdet_fsm
  import bdet_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      low_v_i,
  input  logic      rech_hi_i,
  input  logic      rech_fall_i,
  input  logic      expire_i,
  output logic      clr_o,
  output bdet_win_e win_o,
  output logic      sink_en_o,
  output logic      wake_en_o,
  output logic      present_o,
  output logic      absent_o
);

  bdet_state_e state_q, state_d;
  logic        found, lost;

  always_comb begin
    state_d = state_q;
    found   = 1'b0;
    lost    = 1'b0;
    if (!start_i) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  state_d = ST_SINK;
        ST_SINK: begin
          // threshold crossing beats a coincident window expiry
          if (low_v_i)       state_d = ST_GAP_W;
          else if (expire_i) begin state_d = ST_MON; found = 1'b1; end
        end
        ST_GAP_W: if (expire_i) state_d = ST_WAKE;
        ST_WAKE: begin
          if (rech_hi_i)     begin state_d = ST_GAP_S; lost = 1'b1; end
          else if (expire_i) begin state_d = ST_MON;  found = 1'b1; end
        end
        ST_GAP_S: if (expire_i) state_d = ST_SINK;
        ST_MON:   if (rech_fall_i) state_d = ST_SINK;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      present_o <= 1'b0;
      absent_o  <= 1'b0;
    end else begin
      state_q   <= state_d;
      present_o <= found;
      if (found)     absent_o <= 1'b0;
      else if (lost) absent_o <= 1'b1;
    end
  end

  always_comb begin
    case (state_q)
      ST_SINK:            win_o = WIN_SINK;
      ST_WAKE:            win_o = WIN_WAKE;
      ST_GAP_W, ST_GAP_S: win_o = WIN_GAP;
      default:            win_o = WIN_NONE;
    endcase
  end

  assign clr_o     = (state_d != state_q);
  assign sink_en_o = (state_q == ST_SINK);
  assign wake_en_o = (state_q == ST_WAKE);

  // R8
  a_r8_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sink_en_o && wake_en_o));
  a_r8_gap_before_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_en_o) |-> !$past(sink_en_o));
  a_r8_gap_before_sink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sink_en_o) |-> !$past(wake_en_o));
  // R7
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    present_o |=> !present_o);
  a_r7_present_clears_absent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    present_o |-> !absent_o);
  // R9
  a_r9_stop_sources: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!sink_en_o && !wake_en_o && !present_o));
  // R2
  a_r2_start_sink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> sink_en_o);
  // R5
  a_r5_absent_from_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(absent_o) |-> ($past(wake_en_o) && !wake_en_o && !sink_en_o));
  // R3
  a_r3_low_stops_sink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sink_en_o && low_v_i && start_i) |=> (!sink_en_o && !wake_en_o && !present_o));
  // R10
  a_r10_rerun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MON && start_i && rech_fall_i) |=> sink_en_o);

endmodule

// File: rtl/bdet_seq.sv
module bdet_seq
  import bdet_pkg::*;
#(
  parameter int SINK_TICKS = 1000,
  parameter int WAKE_TICKS = 500,
  parameter int GAP_TICKS  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  input  logic low_v_i,
  input  logic rech_hi_i,
  output logic sink_en_o,
  output logic wake_en_o,
  output logic present_o,
  output logic absent_o
);

  localparam int MAX_SW = (SINK_TICKS > WAKE_TICKS) ? SINK_TICKS : WAKE_TICKS;
  localparam int MAX_T  = (MAX_SW > GAP_TICKS) ? MAX_SW : GAP_TICKS;
  localparam int CW     = (MAX_T > 1) ? $clog2(MAX_T) : 1;

  logic      clr, expire, rech_fall;
  bdet_win_e win;

  bdet_fall_det u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (rech_hi_i),
    .fall_o (rech_fall)
  );

  bdet_win_timer #(
    .SINK_TICKS (SINK_TICKS),
    .WAKE_TICKS (WAKE_TICKS),
    .GAP_TICKS  (GAP_TICKS),
    .CW         (CW)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .tick_i   (tick_i),
    .win_i    (win),
    .expire_o (expire)
  );

  bdet_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .low_v_i     (low_v_i),
    .rech_hi_i   (rech_hi_i),
    .rech_fall_i (rech_fall),
    .expire_i    (expire),
    .clr_o       (clr),
    .win_o       (win),
    .sink_en_o   (sink_en_o),
    .wake_en_o   (wake_en_o),
    .present_o   (present_o),
    .absent_o    (absent_o)
  );

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!sink_en_o && !wake_en_o && !present_o && !absent_o));

endmodule

// File: tb/tb_bdet_seq.sv
module tb_bdet_seq;

  localparam int SINK = 6;
  localparam int WAKE = 4;
  localparam int GAP  = 1;
  localparam int NV   = 6;
  // {ticks before low_v in sink (0 = never), ticks before rech_hi in wake (0 = never)}
  localparam int VEC [NV][2] = '{'{0, 0}, '{3, 0}, '{1, 2}, '{2, 4}, '{6, 0}, '{1, 1}};

  logic clk = 1'b0;
  logic rst_ni, start_i, tick_i, low_v_i, rech_hi_i;
  logic sink_en_o, wake_en_o, present_o, absent_o;
  int   n_chk = 0, n_bad = 0;
  logic exp_abs = 1'b0;

  always #4 clk = ~clk;

  bdet_seq #(.SINK_TICKS(SINK), .WAKE_TICKS(WAKE), .GAP_TICKS(GAP)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .tick_i(tick_i),
    .low_v_i(low_v_i), .rech_hi_i(rech_hi_i), .sink_en_o(sink_en_o),
    .wake_en_o(wake_en_o), .present_o(present_o), .absent_o(absent_o)
  );

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {sink_en_o, wake_en_o, present_o, absent_o};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {sink,wake,present,absent} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tk();
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  // Sink probe to its own timeout; leaves the sequencer in monitoring with start held.
  task automatic sink_timeout(input string req);
    repeat (SINK - 1) tk();
    chk({req, " sink still on before last tick"}, {3'b100, exp_abs});
    tk();
    exp_abs = 1'b0;
    chk({req, " R4 present after sink window"}, 4'b0010);
    step();
    chk({req, " R7 pulse one cycle"}, 4'b0000);
  endtask

  task automatic run_vec(input int lo_at, input int hi_at);
    start_i = 1'b1; low_v_i = 1'b0; rech_hi_i = 1'b0;
    step();
    chk("R2 sink on after start", {3'b100, exp_abs});
    if (lo_at == 0) begin
      sink_timeout("R4");
    end else begin
      repeat (lo_at - 1) tk();
      low_v_i = 1'b1;
      step();
      chk("R3 sink off on low_v", {3'b000, exp_abs});
      low_v_i = 1'b0;
      step();
      chk("R8 both off in gap", {3'b000, exp_abs});
      repeat (GAP) tk();
      chk("R3 wake on after gap", {3'b010, exp_abs});
      if (hi_at == 0) begin
        repeat (WAKE - 1) tk();
        chk("R6 wake still on before last tick", {3'b010, exp_abs});
        tk();
        exp_abs = 1'b0;
        chk("R6 present after wake window", 4'b0010);
        step();
        chk("R7 pulse one cycle", 4'b0000);
      end else begin
        repeat (hi_at - 1) tk();
        rech_hi_i = 1'b1;
        step();
        exp_abs = 1'b1;
        chk("R5 absent, sources off", 4'b0001);
        rech_hi_i = 1'b0;
        repeat (GAP) tk();
        chk("R5 sink probe restarts", 4'b1001);
      end
    end
    start_i = 1'b0;
    step();
    chk("R9 idle after start drop", {3'b000, exp_abs});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; tick_i = 1'b0; low_v_i = 1'b0; rech_hi_i = 1'b0;
    repeat (3) step();
    chk("R1 reset outputs", 4'b0000);
    rst_ni = 1'b1;
    step();
    chk("R1 idle after reset", 4'b0000);

    for (int i = 0; i < NV; i++) run_vec(VEC[i][0], VEC[i][1]);

    // R7: absent is left set by the last vector and must hold through idle
    step();
    chk("R7 absent held in idle", 4'b0001);
    start_i = 1'b1;
    step();
    chk("R7 absent held in new probe", 4'b1001);
    sink_timeout("R7");
    start_i = 1'b0; step();

    // R3: low_v together with the final sink tick gives no present result
    start_i = 1'b1; step();
    repeat (SINK - 1) tk();
    low_v_i = 1'b1; tick_i = 1'b1;
    step();
    tick_i = 1'b0; low_v_i = 1'b0;
    chk("R3 low_v beats expiry", 4'b0000);
    step();
    chk("R3 no late present", 4'b0000);
    start_i = 1'b0; step();

    // R9: abort in the middle of the wake probe
    start_i = 1'b1; step();
    low_v_i = 1'b1; step(); low_v_i = 1'b0;
    repeat (GAP) tk();
    tk();
    chk("R9 wake running", 4'b0100);
    start_i = 1'b0;
    step();
    chk("R9 wake stopped", 4'b0000);
    repeat (WAKE) tk();
    chk("R9 no present while idle", 4'b0000);

    // R10: rerun on a falling recharge flag while monitoring
    start_i = 1'b1; step();
    sink_timeout("R10");
    rech_hi_i = 1'b1;
    step();
    chk("R10 rising flag ignored", 4'b0000);
    step();
    chk("R10 still monitoring", 4'b0000);
    rech_hi_i = 1'b0;
    step();
    chk("R10 rerun on falling flag", 4'b1000);

    // R1: asynchronous reset mid-run clears absent too
    low_v_i = 1'b1; step(); low_v_i = 1'b0;
    repeat (GAP) tk();
    rech_hi_i = 1'b1; step(); rech_hi_i = 1'b0;
    chk("R5 absent before reset", 4'b0001);
    #1 rst_ni = 1'b0;
    #1 chk("R1 async reset clears all", 4'b0000);
    step();
    rst_ni = 1'b1; start_i = 1'b0;
    step();
    chk("R1 idle after second reset", 4'b0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule